// File: doc/BRIEF.md
# Converter Step Sequencer with Standby and SYNC Control

This block is the control state machine that walks a data acquisition converter through one operation at a time. An operation is either a conversion or a limit comparison. The block optionally inserts an auto-zero step ahead of it, then tells the converter which step to run through single-cycle start strobes. It waits for the converter's done handshake after each step and reports the end of the operation with a one-cycle pulse. The caller marks a pending operation by holding `op_req` high and says whether it is a comparison with `op_cmp`.

A shared SYNC line has two roles, and a configuration bit picks one. As an input, a rising edge on the line, passed through a synchronizer, triggers the pending operation. As an output, the line is driven high for exactly as long as an operation is in flight. A standby bit gates the internal clock enable and aborts any step in progress. Clearing the standby bit returns the block to its reset state. A settling window then runs, after which a standby-complete pulse goes to the interrupt logic. No operation may start before that pulse.

Top module: `adc_step_sequencer`

## Requirements
- R1: After `rst` is held high across a clock edge, `busy`, `az_start`, `cv_start`, `op_done`, `stby_done` and `step_cmp` are 0, `clk_en` is 1, and `sync_oe` equals `cfg_sync_out`.
- R2: A clock edge that samples `cfg_standby`=1 aborts any operation. From that edge on, `clk_en` and `busy` are 0, no strobe is issued, and `step_cmp` is cleared, until standby is left.
- R3: On the first edge that samples `cfg_standby`=0 while in standby, `clk_en` returns to 1. `stby_done` is a one-cycle pulse that follows exactly SETTLE_CYC+1 edges after that point, counting that edge as the first.
- R4: While in standby and during the settling window, `op_req`, SYNC edges and `conv_done` have no effect. A request held through the window starts on the edge after the `stby_done` pulse.
- R5: With `cfg_autozero`=1, an operation begins with an `az_start` pulse. `cv_start` pulses in the cycle after an edge that samples `conv_done`=1 during the auto-zero step.
- R6: With `cfg_autozero`=0, an operation begins directly with a `cv_start` pulse and no `az_start`.
- R7: `busy` is 1 from the cycle of the operation's first start strobe to the cycle before `op_done`. `sync_o` equals `busy`, and `sync_oe` equals `cfg_sync_out` (1 = SYNC drives out).
- R8: In output mode (`cfg_sync_out`=1), an idle edge that samples `op_req`=1 starts an operation at that edge.
- R9: In input mode (`cfg_sync_out`=0), an operation starts on the third clock edge after `sync_i` rises, provided `op_req` is 1 when that edge samples it. Neither a high `op_req` alone nor a `sync_i` held high starts an operation.
- R10: A `sync_i` rising edge that reaches the detector while an operation is in progress is dropped and not remembered.
- R11: `op_cmp` is captured when an operation starts and is held on `step_cmp` until the operation ends, whatever `op_cmp` does meanwhile.
- R12: `op_done` is a one-cycle pulse in the cycle after the edge that samples `conv_done`=1 during the conversion step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_standby | input | 1 | 1 = enter standby |
| cfg_autozero | input | 1 | 1 = auto-zero step before each operation |
| cfg_sync_out | input | 1 | 1 = SYNC is an output, 0 = SYNC is an input |
| op_req | input | 1 | An operation is pending |
| op_cmp | input | 1 | Pending operation is a limit comparison |
| sync_i | input | 1 | SYNC pad input level |
| sync_o | output | 1 | SYNC pad output level (busy indication) |
| sync_oe | output | 1 | SYNC pad output enable |
| az_start | output | 1 | Start auto-zero step (one-cycle) |
| cv_start | output | 1 | Start conversion/comparison step (one-cycle) |
| step_cmp | output | 1 | Captured operation kind for the converter |
| conv_done | input | 1 | Converter finished the current step |
| busy | output | 1 | Operation in progress |
| op_done | output | 1 | Operation finished (one-cycle) |
| clk_en | output | 1 | Internal clock enable, low in standby |
| stby_done | output | 1 | Standby-complete event (one-cycle) |

## Verification
The bench builds the block with SETTLE_CYC=4 and the default two-stage synchronizer. The short window lets every cycle of the settling period be checked against the completion pulse, and it shows that a request held through the window starts one edge after the pulse. The operation sweep is exhaustive over SYNC direction, auto-zero, operation kind and converter latencies of 0 to 2 extra cycles. Each converter response can therefore be placed at a known cycle offset from its start strobe. Directed runs raise SYNC edges while an operation is in flight, hold SYNC high after it ends, and enter standby mid-operation.

// File: rtl/adc_seq_pkg.sv
`timescale 1ns/1ps
package adc_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_AZ     = 3'd1,
        ST_CONV   = 3'd2,
        ST_STBY   = 3'd3,
        ST_SETTLE = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic standby;
        logic autozero;
        logic sync_drive;
    } seq_cfg_t;

    typedef struct packed {
        logic az_start;
        logic cv_start;
        logic op_done;
        logic stby_done;
    } seq_strobe_t;

    function automatic logic state_active(input seq_state_e s);
        return (s == ST_AZ) || (s == ST_CONV);
    endfunction

    function automatic logic state_powered(input seq_state_e s);
        return s != ST_STBY;
    endfunction

endpackage

// File: rtl/adc_seq_sync_edge.sv
`timescale 1ns/1ps
module adc_seq_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    input  logic din,
    output logic rise
);
    // chain[0..STAGES-1] synchronize, chain[STAGES] holds the previous level
    logic [STAGES:0] chain;

    for (genvar i = 0; i <= STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst || clr) chain[i] <= 1'b0;
                else            chain[i] <= din;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst || clr) chain[i] <= 1'b0;
                else            chain[i] <= chain[i-1];
            end
        end
    end

    assign rise = chain[STAGES-1] & ~chain[STAGES];

    // R9: an edge is reported for one cycle only
    assert_rise_single_R9: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);

endmodule

// File: rtl/adc_seq_settle_timer.sv
`timescale 1ns/1ps
module adc_seq_settle_timer #(
    parameter int SETTLE_CYC = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic expired
);
    localparam int CNT_W = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SETTLE_CYC - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run)      cnt <= '0;
        else if (cnt != LAST) cnt <= cnt + 1'b1;
    end

    assign expired = run && (cnt == LAST);

    // R3: window ends once, then the sequencer leaves the settling state
    assert_expire_once_R3: assert property (@(posedge clk) disable iff (rst)
        expired |=> !expired);

    // R3: the counter restarts from zero each time the window opens
    assert_count_start_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(run) |-> (cnt == '0));

endmodule

// File: rtl/adc_seq_fsm.sv
`timescale 1ns/1ps
module adc_seq_fsm
    import adc_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  seq_cfg_t    cfg,
    input  logic        op_req,
    input  logic        op_cmp,
    input  logic        sync_rise,
    input  logic        conv_done,
    input  logic        settle_expired,
    output seq_strobe_t strobe,
    output logic        step_cmp,
    output logic        busy,
    output logic        clk_en,
    output logic        settle_run,
    output logic        edge_clr
);
    seq_state_e  state, state_nx;
    seq_strobe_t strobe_nx;
    logic        start_ok;
    logic        step_cmp_nx;

    assign start_ok = (state == ST_IDLE) && op_req && (cfg.sync_drive || sync_rise);

    always_comb begin
        state_nx    = state;
        strobe_nx   = '0;
        step_cmp_nx = step_cmp;
        if (cfg.standby) begin
            state_nx    = ST_STBY;
            step_cmp_nx = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        step_cmp_nx = op_cmp;
                        if (cfg.autozero) begin
                            state_nx           = ST_AZ;
                            strobe_nx.az_start = 1'b1;
                        end else begin
                            state_nx           = ST_CONV;
                            strobe_nx.cv_start = 1'b1;
                        end
                    end
                end
                ST_AZ: begin
                    if (conv_done) begin
                        state_nx           = ST_CONV;
                        strobe_nx.cv_start = 1'b1;
                    end
                end
                ST_CONV: begin
                    if (conv_done) begin
                        state_nx          = ST_IDLE;
                        strobe_nx.op_done = 1'b1;
                        step_cmp_nx       = 1'b0;
                    end
                end
                ST_STBY: begin
                    state_nx = ST_SETTLE;
                end
                ST_SETTLE: begin
                    if (settle_expired) begin
                        state_nx            = ST_IDLE;
                        strobe_nx.stby_done = 1'b1;
                    end
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            strobe   <= '0;
            step_cmp <= 1'b0;
        end else begin
            state    <= state_nx;
            strobe   <= strobe_nx;
            step_cmp <= step_cmp_nx;
        end
    end

    assign busy       = state_active(state);
    assign clk_en     = state_powered(state);
    assign settle_run = (state == ST_SETTLE);
    assign edge_clr   = (state == ST_STBY);

    // R2: standby sampled -> powered down and idle on the next cycle
    assert_stby_entry_R2: assert property (@(posedge clk) disable iff (rst)
        cfg.standby |=> (!clk_en && !busy && !strobe.az_start && !strobe.cv_start));

    // R4: nothing starts while settling
    assert_settle_quiet_R4: assert property (@(posedge clk) disable iff (rst)
        settle_run |=> (!strobe.az_start && !strobe.cv_start && !busy));

    // R5: an auto-zero strobe only follows an enabled auto-zero bit
    assert_az_gated_R5: assert property (@(posedge clk) disable iff (rst)
        strobe.az_start |-> $past(cfg.autozero));

    // R6: a direct conversion start from idle means auto-zero was off
    assert_direct_conv_R6: assert property (@(posedge clk) disable iff (rst)
        (strobe.cv_start && $past(state == ST_IDLE)) |-> !$past(cfg.autozero));

    // R10: without a converter response the in-flight step holds, no new start
    assert_no_restart_R10: assert property (@(posedge clk) disable iff (rst)
        (busy && !conv_done && !cfg.standby) |=> (busy && !strobe.az_start && !strobe.cv_start));

    // R12: completion is a single pulse and leaves the block idle
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (rst)
        strobe.op_done |-> (!busy && clk_en));

    // R7: strobes never overlap
    assert_strobe_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));

endmodule

// File: rtl/adc_step_sequencer.sv
`timescale 1ns/1ps
module adc_step_sequencer
    import adc_seq_pkg::*;
#(
    parameter int SETTLE_CYC  = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_standby,
    input  logic cfg_autozero,
    input  logic cfg_sync_out,
    input  logic op_req,
    input  logic op_cmp,
    input  logic sync_i,
    output logic sync_o,
    output logic sync_oe,
    output logic az_start,
    output logic cv_start,
    output logic step_cmp,
    input  logic conv_done,
    output logic busy,
    output logic op_done,
    output logic clk_en,
    output logic stby_done
);
    seq_cfg_t    cfg;
    seq_strobe_t strobe;
    logic        sync_rise;
    logic        edge_clr;
    logic        settle_run;
    logic        settle_expired;

    assign cfg = '{standby: cfg_standby, autozero: cfg_autozero, sync_drive: cfg_sync_out};

    adc_seq_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .clr  (edge_clr),
        .din  (sync_i),
        .rise (sync_rise)
    );

    adc_seq_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_settle (
        .clk     (clk),
        .rst     (rst),
        .run     (settle_run),
        .expired (settle_expired)
    );

    adc_seq_fsm u_fsm (
        .clk            (clk),
        .rst            (rst),
        .cfg            (cfg),
        .op_req         (op_req),
        .op_cmp         (op_cmp),
        .sync_rise      (sync_rise),
        .conv_done      (conv_done),
        .settle_expired (settle_expired),
        .strobe         (strobe),
        .step_cmp       (step_cmp),
        .busy           (busy),
        .clk_en         (clk_en),
        .settle_run     (settle_run),
        .edge_clr       (edge_clr)
    );

    assign az_start  = strobe.az_start;
    assign cv_start  = strobe.cv_start;
    assign op_done   = strobe.op_done;
    assign stby_done = strobe.stby_done;
    assign sync_o    = busy;
    assign sync_oe   = cfg_sync_out;

    // R11: captured kind is stable during an operation
    assert_kind_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(step_cmp));

    // R3: completion event is only raised with the clock running and idle
    assert_stby_done_R3: assert property (@(posedge clk) disable iff (rst)
        stby_done |-> (clk_en && !busy));

endmodule

// File: tb/adc_step_sequencer_tb.sv
`timescale 1ns/1ps
module adc_step_sequencer_tb_top;
    localparam int S = 4;

    logic clk = 1'b0;
    logic rst, cfg_standby, cfg_autozero, cfg_sync_out, op_req, op_cmp, sync_i, conv_done;
    logic sync_o, sync_oe, az_start, cv_start, step_cmp, busy, op_done, clk_en, stby_done;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    adc_step_sequencer #(.SETTLE_CYC(S), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .rst(rst), .cfg_standby(cfg_standby), .cfg_autozero(cfg_autozero),
        .cfg_sync_out(cfg_sync_out), .op_req(op_req), .op_cmp(op_cmp), .sync_i(sync_i),
        .sync_o(sync_o), .sync_oe(sync_oe), .az_start(az_start), .cv_start(cv_start),
        .step_cmp(step_cmp), .conv_done(conv_done), .busy(busy), .op_done(op_done),
        .clk_en(clk_en), .stby_done(stby_done)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%b exp=%b t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic quiet(input string tag);
        chk({tag, " az_start"}, az_start, 1'b0);
        chk({tag, " cv_start"}, cv_start, 1'b0);
    endtask

    task automatic run_op(input bit mode, input bit az, input bit cmp, input int lat);
        cfg_sync_out = mode;
        cfg_autozero = az;
        op_cmp       = cmp;
        op_req       = 1'b1;
        if (mode) begin
            tick();  // R8: starts at the first edge
        end else begin
            sync_i = 1'b1;
            tick(); chk("R9 busy edge1", busy, 1'b0);
            tick(); chk("R9 busy edge2", busy, 1'b0);
            tick();
        end
        op_req = 1'b0;
        op_cmp = ~cmp;
        sync_i = 1'b0;
        chk("R7 busy start", busy, 1'b1);
        chk("R7 sync_o start", sync_o, 1'b1);
        chk("R7 sync_oe", sync_oe, mode);
        chk("R5 az_start", az_start, az);
        chk("R6 cv_start", cv_start, !az);
        chk("R11 step_cmp", step_cmp, cmp);
        if (az) begin
            for (int k = 0; k < lat; k++) begin
                tick(); quiet("R10 az wait"); chk("R7 busy az", busy, 1'b1);
            end
            conv_done = 1'b1; tick(); conv_done = 1'b0;
            chk("R5 cv after az", cv_start, 1'b1);
            chk("R5 no az again", az_start, 1'b0);
            chk("R11 step_cmp held", step_cmp, cmp);
        end
        for (int k = 0; k < lat; k++) begin
            tick(); quiet("R10 cv wait"); chk("R7 busy cv", busy, 1'b1);
            chk("R12 no early done", op_done, 1'b0);
        end
        conv_done = 1'b1; tick(); conv_done = 1'b0;
        chk("R12 op_done", op_done, 1'b1);
        chk("R7 busy end", busy, 1'b0);
        chk("R7 sync_o end", sync_o, 1'b0);
        tick();
        chk("R12 op_done pulse", op_done, 1'b0);
        chk("R8 stays idle", busy, 1'b0);
        tick();
    endtask

    initial begin
        rst = 1'b1; cfg_standby = 0; cfg_autozero = 0; cfg_sync_out = 0;
        op_req = 0; op_cmp = 0; sync_i = 0; conv_done = 0;
        repeat (3) tick();
        rst = 1'b0;
        tick();
        // R1: reset state
        chk("R1 busy", busy, 1'b0);
        chk("R1 clk_en", clk_en, 1'b1);
        chk("R1 op_done", op_done, 1'b0);
        chk("R1 stby_done", stby_done, 1'b0);
        chk("R1 step_cmp", step_cmp, 1'b0);
        chk("R1 sync_oe", sync_oe, 1'b0);
        quiet("R1");

        // Exhaustive sweep: direction x auto-zero x kind x latency
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 2; a++)
                for (int c = 0; c < 2; c++)
                    for (int l = 0; l < 3; l++)
                        run_op(m[0], a[0], c[0], l);

        // R10: edge during an operation is dropped
        cfg_sync_out = 0; cfg_autozero = 1; op_cmp = 0;
        op_req = 1; sync_i = 1;
        repeat (3) tick();
        chk("R10 started", busy, 1'b1);
        sync_i = 0; tick(); tick();
        sync_i = 1;
        for (int k = 0; k < 4; k++) begin
            tick(); quiet("R10 edge in flight"); chk("R10 busy", busy, 1'b1);
        end
        conv_done = 1; tick(); conv_done = 0;
        chk("R10 cv", cv_start, 1'b1);
        conv_done = 1; tick(); conv_done = 0;
        chk("R10 done", op_done, 1'b1);
        for (int k = 0; k < 4; k++) begin
            tick(); chk("R10 no replay", busy, 1'b0); chk("R9 held level", busy, 1'b0);
        end
        // R9: edge without a pending request
        op_req = 0; sync_i = 0;
        repeat (3) tick();
        sync_i = 1;
        for (int k = 0; k < 5; k++) begin
            tick(); chk("R9 no req", busy, 1'b0);
        end
        sync_i = 0;
        repeat (3) tick();

        // R2 / R3 / R4: standby mid-operation
        cfg_sync_out = 1; cfg_autozero = 1; op_cmp = 1; op_req = 1;
        tick();
        chk("R2 pre busy", busy, 1'b1);
        chk("R2 pre kind", step_cmp, 1'b1);
        op_req = 0;
        cfg_standby = 1;
        tick();
        chk("R2 clk_en", clk_en, 1'b0);
        chk("R2 busy", busy, 1'b0);
        chk("R2 step_cmp", step_cmp, 1'b0);
        op_req = 1;
        for (int k = 0; k < 3; k++) begin
            conv_done = k[0];
            tick();
            chk("R4 stby busy", busy, 1'b0);
            chk("R2 stby clk_en", clk_en, 1'b0);
            chk("R4 stby op_done", op_done, 1'b0);
            quiet("R4 stby");
        end
        conv_done = 0;
        cfg_standby = 0;
        for (int k = 1; k <= S + 2; k++) begin
            tick();
            chk("R3 clk_en", clk_en, 1'b1);
            chk("R3 stby_done", stby_done, (k == S + 1));
            chk("R4 settle start", busy, (k == S + 2));
        end
        chk("R4 az after settle", az_start, 1'b1);
        op_req = 0;
        conv_done = 1; tick(); tick(); conv_done = 0;
        chk("R12 after standby", op_done, 1'b1);
        tick();

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1600000;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R12 act=hung exp=complete");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule